// File: doc/BRIEF.md
# Serial Lane Bit and Word Alignment Lock

This block sits behind the deserializer of one serial ADC data lane and brings that lane into alignment. It takes one parallel word per clock. In the first stage it compares each word against a fixed training word. While they differ, it asks the deserializer to shift its bit phase by one position, using a single-cycle slip pulse. After each slip it waits a fixed settle time before it compares again. The bit stage locks once the training word has been seen on a run of consecutive compares.

In the second stage the block looks for a header word that opens every frame of fixed length. It then checks that header at each expected frame slot. The lane is declared locked once the header has matched on a run of consecutive slots.

After lock, the block keeps checking every header slot. A slot word that is a shifted copy of the header points to lost bit alignment. Any other wrong word points to a lost frame boundary. A loss is declared only when enough errors of one kind fall inside one window of slots, so isolated faults do not drop lock. A bit loss restarts bit training. A word loss restarts the header search. Two saturating counters record every error event for later inspection.

Top module: `lane_align_lock`

## Requirements
- R1: While reset is held and right after it, bit_slip, bit_locked, lane_locked, lane_unlock, word_misalign and training_fail are 0, and both error counters read 0.
- R2: In bit training, a compare that does not match the training word produces a one-cycle bit_slip pulse. The block then makes no compare for SETTLE cycles. From a lane that is k bit positions off (0 < k < DATA_W) and needs DATA_W-k slips, bit lock takes (DATA_W-k)*(SETTLE+1)+LOCK_RUN words.
- R3: bit_locked rises only after LOCK_RUN consecutive compared words equal the training word. It is still 0 after LOCK_RUN-1 such words.
- R4: If DATA_W slips occur without bit lock, training_fail is set and the slip count restarts while slipping continues. training_fail clears when bit lock is reached.
- R5: After bit lock, the first header word marks frame slot 0, and slots recur every FRAME_LEN words. lane_locked rises on the LOCK_RUN-th consecutive matching header. A non-header word at an expected slot restarts the header search.
- R6: While locked, a slot word that equals the header rotated by a nonzero amount counts as a bit error. Any other non-header slot word counts as a word error.
- R7: Lock drops only when ERR_LIMIT errors of one kind fall in one window of WIN_SLOTS slots. Windows are back to back and the first one starts at lock. Errors in separate windows never drop lock.
- R8: A bit-error loss sets lane_unlock, clears bit_locked and lane_locked, and restarts bit training. A word-error loss sets word_misalign and clears lane_locked while bit_locked stays 1. Both flags clear when lane_locked is regained.
- R9: bit_err_cnt and word_err_cnt each add one per error event of their kind and hold at all ones instead of wrapping.
- R10: clr_err high at a clock edge makes both counters read 0 after that edge, even if an error event occurs at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | DATA_W | Deserialized lane word |
| clr_err | input | 1 | Zeroes both error counters |
| bit_slip | output | 1 | One-cycle request to shift the bit phase by one |
| bit_locked | output | 1 | Bit alignment reached |
| lane_locked | output | 1 | Bit and frame alignment reached |
| lane_unlock | output | 1 | Last loss of lock was a bit-alignment loss |
| word_misalign | output | 1 | Last loss of lock was a frame-boundary loss |
| training_fail | output | 1 | A full slip sweep found no training match |
| bit_err_cnt | output | ERR_CNT_W | Saturating count of bit errors |
| word_err_cnt | output | ERR_CNT_W | Saturating count of word errors |

## Verification
The properties assume the lane reacts to a slip request before the settle count ends. They also assume the transmitter sends only training words during bit training, and header-led frames of exactly FRAME_LEN words afterwards. They further assume that the header's rotations are all distinct and that no data word is a rotation of the header. The stimulus models the lane as a rotation offset that moves by one on each observed slip pulse and is applied to the next driven word. Its payload words have a bit count different from the header's, so they never look like a shifted header.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  typedef enum logic [1:0] {
    ST_BIT   = 2'd0,
    ST_WSRCH = 2'd1,
    ST_WQUAL = 2'd2,
    ST_LOCK  = 2'd3
  } align_state_t;

  localparam int ERR_BIT  = 0;
  localparam int ERR_WORD = 1;
  localparam int ERR_KINDS = 2;

endpackage

// File: rtl/lane_word_classify.sv
module lane_word_classify #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] TRAIN_PAT = 16'hA5C3,
  parameter logic [DATA_W-1:0] HDR_PAT = 16'hF4C1
) (
  input  logic [DATA_W-1:0] rx_word,
  output logic              train_hit,
  output logic              hdr_hit,
  output logic              hdr_rot_hit
);

  function automatic logic [DATA_W-1:0] rot_by(input logic [DATA_W-1:0] w, input int n);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[(i + n) % DATA_W] = w[i];
    return r;
  endfunction

  function automatic logic is_shifted(input logic [DATA_W-1:0] w, input logic [DATA_W-1:0] ref_w);
    logic hit;
    hit = 1'b0;
    for (int n = 1; n < DATA_W; n++) if (rot_by(ref_w, n) == w) hit = 1'b1;
    return hit;
  endfunction

  assign train_hit   = (rx_word == TRAIN_PAT);
  assign hdr_hit     = (rx_word == HDR_PAT);
  assign hdr_rot_hit = is_shifted(rx_word, HDR_PAT);

endmodule

// File: rtl/lane_err_window.sv
module lane_err_window #(
  parameter int ERR_LIMIT = 2,
  parameter int WIN_SLOTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slot,
  input  logic bit_err,
  input  logic word_err,
  output logic bit_drop,
  output logic word_drop
);

  localparam int CW = $clog2(ERR_LIMIT + 1);
  localparam int WW = $clog2(WIN_SLOTS + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_SLOTS - 1);

  logic [WW-1:0] win_cnt;
  logic [CW-1:0] bit_n, word_n;

  function automatic logic reaches(input logic [CW-1:0] n, input logic inc);
    return (int'(n) + int'(inc)) >= ERR_LIMIT;
  endfunction

  assign bit_drop  = slot && bit_err  && reaches(bit_n, 1'b1);
  assign word_drop = slot && word_err && reaches(word_n, 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      win_cnt <= '0;
      bit_n   <= '0;
      word_n  <= '0;
    end else if (slot) begin
      if (win_cnt == WIN_LAST) begin
        win_cnt <= '0;
        bit_n   <= '0;
        word_n  <= '0;
      end else begin
        win_cnt <= win_cnt + WW'(1);
        bit_n   <= bit_n + CW'(bit_err);
        word_n  <= word_n + CW'(word_err);
      end
    end
  end

endmodule

// File: rtl/lane_sat_counter.sv
module lane_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && (cnt != '1)) cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/lane_align_lock.sv
module lane_align_lock
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] TRAIN_PAT = 16'hA5C3,
  parameter logic [DATA_W-1:0] HDR_PAT = 16'hF4C1,
  parameter int LOCK_RUN = 4,
  parameter int SETTLE = 3,
  parameter int FRAME_LEN = 8,
  parameter int ERR_LIMIT = 2,
  parameter int WIN_SLOTS = 4,
  parameter int ERR_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    rx_word,
  input  logic                 clr_err,
  output logic                 bit_slip,
  output logic                 bit_locked,
  output logic                 lane_locked,
  output logic                 lane_unlock,
  output logic                 word_misalign,
  output logic                 training_fail,
  output logic [ERR_CNT_W-1:0] bit_err_cnt,
  output logic [ERR_CNT_W-1:0] word_err_cnt
);

  localparam int SLIP_W = $clog2(DATA_W);
  localparam int POS_W  = $clog2(FRAME_LEN);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam logic [SLIP_W-1:0] SLIP_LAST = SLIP_W'(DATA_W - 1);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FRAME_LEN - 1);

  align_state_t      state;
  logic [SET_W-1:0]  settle_cnt;
  logic [SLIP_W-1:0] slip_cnt;
  logic [RUN_W-1:0]  run_cnt;
  logic [POS_W-1:0]  pos;

  // Named internal events
  logic train_hit, hdr_hit, hdr_rot_hit;
  logic cmp_en, at_slot, mon_slot, ev_bit_err, ev_word_err;
  logic bit_drop, word_drop, sweep_done;
  logic [ERR_KINDS-1:0] err_inc;
  logic [ERR_CNT_W-1:0] cnt_q [ERR_KINDS];

  function automatic logic run_done(input logic [RUN_W-1:0] r);
    return (int'(r) + 1) >= LOCK_RUN;
  endfunction

  lane_word_classify #(
    .DATA_W(DATA_W), .TRAIN_PAT(TRAIN_PAT), .HDR_PAT(HDR_PAT)
  ) u_cls (
    .rx_word(rx_word), .train_hit(train_hit), .hdr_hit(hdr_hit), .hdr_rot_hit(hdr_rot_hit)
  );

  assign cmp_en      = (state == ST_BIT) && (settle_cnt == '0);
  assign at_slot     = (pos == '0);
  assign mon_slot    = (state == ST_LOCK) && at_slot;
  assign ev_bit_err  = mon_slot && !hdr_hit && hdr_rot_hit;
  assign ev_word_err = mon_slot && !hdr_hit && !hdr_rot_hit;
  assign sweep_done  = cmp_en && !train_hit && (slip_cnt == SLIP_LAST);

  lane_err_window #(
    .ERR_LIMIT(ERR_LIMIT), .WIN_SLOTS(WIN_SLOTS)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .restart(state != ST_LOCK), .slot(mon_slot),
    .bit_err(ev_bit_err), .word_err(ev_word_err),
    .bit_drop(bit_drop), .word_drop(word_drop)
  );

  always_comb begin
    err_inc = '0;
    err_inc[ERR_BIT]  = ev_bit_err;
    err_inc[ERR_WORD] = ev_word_err;
  end

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_cnt
    lane_sat_counter #(.W(ERR_CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_err), .inc(err_inc[k]), .cnt(cnt_q[k])
    );
  end

  assign bit_err_cnt  = cnt_q[ERR_BIT];
  assign word_err_cnt = cnt_q[ERR_WORD];
  assign lane_locked  = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_BIT;
      settle_cnt    <= '0;
      slip_cnt      <= '0;
      run_cnt       <= '0;
      pos           <= '0;
      bit_slip      <= 1'b0;
      bit_locked    <= 1'b0;
      lane_unlock   <= 1'b0;
      word_misalign <= 1'b0;
      training_fail <= 1'b0;
    end else begin
      bit_slip <= 1'b0;
      pos      <= (pos == POS_LAST) ? '0 : pos + POS_W'(1);
      case (state)
        ST_BIT: begin
          if (settle_cnt != '0) begin
            settle_cnt <= settle_cnt - SET_W'(1);
          end else if (train_hit) begin
            if (run_done(run_cnt)) begin
              state         <= ST_WSRCH;
              bit_locked    <= 1'b1;
              run_cnt       <= '0;
              slip_cnt      <= '0;
              training_fail <= 1'b0;
            end else begin
              run_cnt <= run_cnt + RUN_W'(1);
            end
          end else begin
            run_cnt    <= '0;
            bit_slip   <= 1'b1;
            settle_cnt <= SET_W'(SETTLE);
            if (sweep_done) begin
              slip_cnt      <= '0;
              training_fail <= 1'b1;
            end else begin
              slip_cnt <= slip_cnt + SLIP_W'(1);
            end
          end
        end
        ST_WSRCH: begin
          if (hdr_hit) begin
            state   <= ST_WQUAL;
            pos     <= POS_W'(1);
            run_cnt <= RUN_W'(1);
          end
        end
        ST_WQUAL: begin
          if (at_slot) begin
            if (!hdr_hit) begin
              state   <= ST_WSRCH;
              run_cnt <= '0;
            end else if (run_done(run_cnt)) begin
              state         <= ST_LOCK;
              run_cnt       <= '0;
              lane_unlock   <= 1'b0;
              word_misalign <= 1'b0;
            end else begin
              run_cnt <= run_cnt + RUN_W'(1);
            end
          end
        end
        default: begin
          if (bit_drop) begin
            state       <= ST_BIT;
            bit_locked  <= 1'b0;
            lane_unlock <= 1'b1;
            settle_cnt  <= '0;
            slip_cnt    <= '0;
            run_cnt     <= '0;
          end else if (word_drop) begin
            state         <= ST_WSRCH;
            word_misalign <= 1'b1;
            run_cnt       <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/lane_align_lock_chk.sv
module lane_align_lock_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_err,
  input logic             bit_slip,
  input logic             bit_locked,
  input logic             lane_locked,
  input logic             lane_unlock,
  input logic             word_misalign,
  input logic [CNT_W-1:0] bit_err_cnt,
  input logic [CNT_W-1:0] word_err_cnt
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  // R2
  slip_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_slip |=> !bit_slip);

  // R2
  slip_when_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_slip |-> !bit_locked);

  // R5
  lane_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_locked |-> bit_locked);

  // R8
  flags_clear_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_locked |-> (!lane_unlock && !word_misalign));

  // R8
  unlock_drops_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_unlock) |-> !bit_locked);

  // R9
  bit_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_err_cnt == FULL && !clr_err) |=> bit_err_cnt == FULL);

  // R9
  word_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_err_cnt == FULL && !clr_err) |=> word_err_cnt == FULL);

  // R9
  cnt_no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_err |=> (bit_err_cnt >= $past(bit_err_cnt) && word_err_cnt >= $past(word_err_cnt)));

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (bit_err_cnt == '0 && word_err_cnt == '0));

endmodule

bind lane_align_lock lane_align_lock_chk #(.CNT_W(ERR_CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .bit_slip(bit_slip),
  .bit_locked(bit_locked), .lane_locked(lane_locked), .lane_unlock(lane_unlock),
  .word_misalign(word_misalign), .bit_err_cnt(bit_err_cnt), .word_err_cnt(word_err_cnt)
);

// File: tb/lane_align_lock_tb.sv
module lane_align_lock_tb;

  localparam int DW = 16;
  localparam logic [15:0] TRAIN = 16'hA5C3;
  localparam logic [15:0] HDR   = 16'hF4C1;
  localparam logic [15:0] FILL  = 16'h0003;
  localparam int RUN = 4, SETT = 3, FLEN = 8, CMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0, clr_err = 1'b0;
  logic [15:0] rx_word = '0;
  logic bit_slip, bit_locked, lane_locked, lane_unlock, word_misalign, training_fail;
  logic [3:0] bit_err_cnt, word_err_cnt;

  typedef enum int {K_BIT, K_WORD} kind_t;
  kind_t exp_q[$];
  int checks = 0, fails = 0, off = 0, slips = 0, exp_bit = 0, exp_word = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_align_lock #(
    .DATA_W(DW), .TRAIN_PAT(TRAIN), .HDR_PAT(HDR), .LOCK_RUN(RUN), .SETTLE(SETT),
    .FRAME_LEN(FLEN), .ERR_LIMIT(2), .WIN_SLOTS(4), .ERR_CNT_W(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .clr_err(clr_err),
    .bit_slip(bit_slip), .bit_locked(bit_locked), .lane_locked(lane_locked),
    .lane_unlock(lane_unlock), .word_misalign(word_misalign),
    .training_fail(training_fail), .bit_err_cnt(bit_err_cnt), .word_err_cnt(word_err_cnt)
  );

  function automatic logic [15:0] lane_rot(logic [15:0] w, int n);
    logic [31:0] d;
    d = {w, w} << (n % 16);
    return d[31:16];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one word per cycle through the modelled lane offset
  task automatic send(logic [15:0] w);
    rx_word = lane_rot(w, off);
    @(negedge clk);
    if (bit_slip) begin
      slips++;
      off = (off + 1) % 16;
    end
  endtask

  task automatic expect_err(kind_t k);
    if (k == K_BIT && exp_bit < CMAX) begin exp_q.push_back(k); exp_bit++; end
    if (k == K_WORD && exp_word < CMAX) begin exp_q.push_back(k); exp_word++; end
  endtask

  // kind: 0 clean, 1 shifted header, 2 foreign word
  task automatic send_slot(int kind, bit scored);
    if (kind == 0) send(HDR);
    else if (kind == 1) begin if (scored) expect_err(K_BIT); send(lane_rot(HDR, 3)); end
    else begin if (scored) expect_err(K_WORD); send(16'h0101); end
  endtask

  task automatic send_fill();
    for (int i = 1; i < FLEN; i++) send(FILL);
  endtask

  task automatic send_frame(int kind, bit scored);
    send_slot(kind, scored);
    send_fill();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    off = 0; slips = 0; exp_bit = 0; exp_word = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: scoreboard of error events
  logic [3:0] prev_b = '0, prev_w = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_b <= '0; prev_w <= '0;
    end else begin
      if (bit_err_cnt > prev_b) begin
        checks++;
        if (exp_q.size() == 0 || exp_q[0] != K_BIT) begin
          fails++;
          $display("FAIL R6 bit error event actual=%0d expected=%0d", K_BIT, (exp_q.size() == 0) ? -1 : int'(exp_q[0]));
        end
        if (exp_q.size() != 0) void'(exp_q.pop_front());
      end
      if (word_err_cnt > prev_w) begin
        checks++;
        if (exp_q.size() == 0 || exp_q[0] != K_WORD) begin
          fails++;
          $display("FAIL R6 word error event actual=%0d expected=%0d", K_WORD, (exp_q.size() == 0) ? -1 : int'(exp_q[0]));
        end
        if (exp_q.size() != 0) void'(exp_q.pop_front());
      end
      prev_b <= bit_err_cnt;
      prev_w <= word_err_cnt;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    // R1 reset state
    chk("R1 bit_locked", bit_locked, 0);
    chk("R1 lane_locked", lane_locked, 0);
    chk("R1 slip/flags", {bit_slip, lane_unlock, word_misalign, training_fail}, 0);
    chk("R1 counters", {bit_err_cnt, word_err_cnt}, 0);

    // R3 exact run length, aligned lane
    repeat (RUN - 1) send(TRAIN);
    chk("R3 not yet locked", bit_locked, 0);
    send(TRAIN);
    chk("R3 locked after run", bit_locked, 1);
    chk("R3 no slips", slips, 0);

    // R5 header search with a restart
    repeat (3) send(FILL);
    send_frame(0, 0);
    send_frame(2, 0);
    repeat (RUN - 1) send_frame(0, 0);
    chk("R5 restart delays lock", lane_locked, 0);
    send_slot(0, 0);
    chk("R5 lane locked", lane_locked, 1);
    send_fill();

    // R6/R7 monitoring with windows of 4 slots
    send_frame(1, 1);
    chk("R7 isolated error keeps lock", lane_locked, 1);
    repeat (6) send_frame(0, 0);
    send_frame(1, 1);
    send_slot(1, 1);
    chk("R7 errors across windows keep lock", lane_locked, 1);
    send_fill();
    send_slot(1, 1);
    chk("R8 bit loss drops lane", lane_locked, 0);
    chk("R8 lane_unlock set", lane_unlock, 1);
    chk("R8 bit_locked cleared", bit_locked, 0);
    chk("R9 bit count", bit_err_cnt, 4);

    // R2 retraining from an offset lane
    off = 3; slips = 0; n = 0;
    while (!bit_locked && n < 300) begin send(TRAIN); n++; end
    chk("R2 slip count", slips, 13);
    chk("R2 training length", n, 13 * (SETT + 1) + RUN);

    repeat (RUN - 1) send_frame(0, 0);
    send_slot(0, 0);
    chk("R8 relock clears lane_unlock", {lane_locked, lane_unlock}, 2);
    send_fill();

    // R8 word loss
    send_frame(2, 1);
    send_slot(2, 1);
    chk("R8 word loss drops lane", lane_locked, 0);
    chk("R8 word_misalign set", word_misalign, 1);
    chk("R8 bit lock kept", bit_locked, 1);
    chk("R9 word count", word_err_cnt, 2);
    send_fill();
    repeat (RUN - 1) send_frame(0, 0);
    send_slot(0, 0);
    chk("R8 relock clears word_misalign", {lane_locked, word_misalign}, 2);
    send_fill();

    // R9 saturation, one error per window
    for (int w = 0; w < 14; w++) begin
      send_frame(1, 1);
      repeat (3) send_frame(0, 0);
    end
    chk("R9 saturated", bit_err_cnt, CMAX);
    chk("R7 sparse errors keep lock", lane_locked, 1);

    // R10 clear wins over a same-edge error
    clr_err = 1'b1;
    send_slot(1, 0);
    clr_err = 1'b0;
    exp_bit = 0; exp_word = 0;
    chk("R10 bit cleared", bit_err_cnt, 0);
    chk("R10 word cleared", word_err_cnt, 0);
    send_fill();
    chk("R9 scoreboard drained", exp_q.size(), 0);

    // R4 full sweep without a match
    do_reset();
    n = 0;
    while (!training_fail && n < 200) begin send(16'h0000); n++; end
    chk("R4 slips at fail", slips, 16);
    chk("R4 training_fail", training_fail, 1);
    n = 0;
    while (!bit_locked && n < 200) begin send(TRAIN); n++; end
    chk("R4 relock after fail", bit_locked, 1);
    chk("R4 fail cleared", training_fail, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule